// File: doc/BRIEF.md
# Word Block Mover With Per-Side Address Stepping

This block moves a programmed number of 32-bit words between a small local register memory and a larger shared memory, one word for each granted shared-memory access. A transfer is set up with a single start strobe. The strobe carries the word count, the first local address, the first shared address, the direction, and two stepping flags. One flag lets the local address advance after each word. The other flag lets the shared address advance after each word.

The two flags are independent, so the same engine covers several uses. With both flags set it copies a block. With one address held fixed it streams words through a single location, such as a device register. To fill a shared region with one value, write toward shared memory with the local address held and the shared address advancing. With a count of one, the local address held and the shared address advancing, the engine reads a single word into a fixed local slot, which lets software pull shared memory one word at a time.

Both memories use single-cycle read/write ports with combinational read data. Access to the shared memory follows a valid/ready rule. `shr_req` is the valid signal and `shr_gnt` is the ready signal, driven by an external arbiter. A word moves only in a cycle where both are high. While `shr_gnt` is low, every output and all internal state stay unchanged, so the arbiter can apply back-pressure for any number of cycles without losing data.

Top module: `blk_xfer_eng`

## Requirements
- R1: After reset, `busy`, `done`, `shr_req`, `shr_we` and `lcl_we` are all low.
- R2: With `cfg_dir`=0 (shared to local), each granted cycle writes `shr_rdata`, read at `shr_addr`, into local memory at `lcl_addr` in that same cycle. `lcl_we` is high only in such a cycle, and `shr_we` stays low.
- R3: With `cfg_dir`=1 (local to shared), each granted cycle writes `lcl_rdata`, read at `lcl_addr`, into shared memory at `shr_addr`. `shr_we` is high while a transfer runs, and `lcl_we` stays low.
- R4: The local address advances by one after each granted word when the local stepping flag was set at start. Otherwise it stays at its start value for the whole transfer.
- R5: The shared address advances by one after each granted word when the shared stepping flag was set at start. Otherwise it stays at its start value for the whole transfer.
- R6: A local-to-shared transfer with the local address held and the shared address advancing writes one identical value into every word of the shared region. Words outside the region are not touched.
- R7: A count of one, with the local address held and the shared address advancing, performs exactly one shared access and writes one word into the fixed local slot.
- R8: While `shr_gnt` is low during a transfer, `shr_req` stays high, both addresses hold, no memory is written, and no word is lost.
- R9: A start with a count of zero raises `done` in the next cycle and makes no memory access.
- R10: `done` is a one-cycle pulse in the cycle after the last granted word. `busy` is low in that same cycle. A count of N with the grant held high gives `done` exactly N cycles after the start is sampled.
- R11: A start pulse while `busy` is high is ignored. The running transfer finishes with its original count and addresses.
- R12: The local address wraps from `LCL_DEPTH-1` to 0, and the shared address wraps from all ones to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start strobe, accepted only while idle |
| cfg_count | input | CNT_W | Number of words to move |
| cfg_lcl_addr | input | LCL_AW | First local address |
| cfg_shr_addr | input | SHR_AW | First shared address |
| cfg_dir | input | 1 | 0: shared to local, 1: local to shared |
| cfg_lcl_inc | input | 1 | Advance the local address after each word |
| cfg_shr_inc | input | 1 | Advance the shared address after each word |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| lcl_addr | output | LCL_AW | Local memory address |
| lcl_we | output | 1 | Local memory write enable |
| lcl_wdata | output | DATA_W | Local memory write data |
| lcl_rdata | input | DATA_W | Local memory read data (combinational) |
| shr_req | output | 1 | Shared access valid |
| shr_gnt | input | 1 | Shared access ready (grant) |
| shr_we | output | 1 | Shared access is a write |
| shr_addr | output | SHR_AW | Shared memory address |
| shr_wdata | output | DATA_W | Shared memory write data |
| shr_rdata | input | DATA_W | Shared memory read data (combinational) |

## Verification
The bench runs transfers under four stepping patterns: both addresses stepping, only the shared address stepping, only the local address stepping, and a count-of-one fetch. Each pattern is checked against memory images that the bench computes itself. Every memory is preloaded with values unique to each address, so a held address, a skipped word or an off-by-one stop each leave a different word in a different place. The grant is driven three ways: always high, which checks the exact latency; pseudo-random, which exercises back-pressure; and held low, which exercises the stall. Further runs cover a zero count, a start pulse during a running transfer, and start addresses near the top of both address ranges, which exercise the wrap.

// File: rtl/blk_xfer_pkg.sv
package blk_xfer_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } bx_state_e;

  // direction encoding on cfg_dir
  localparam logic DIR_SHR_TO_LCL = 1'b0;
  localparam logic DIR_LCL_TO_SHR = 1'b1;

  typedef struct packed {
    logic to_shared;
    logic lcl_step;
    logic shr_step;
  } bx_mode_t;
endpackage

// File: rtl/bx_addr_gen.sv
module bx_addr_gen #(
  parameter int AW    = 8,
  parameter int DEPTH = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          step,
  output logic [AW-1:0] addr
);
  localparam logic [AW-1:0] TOP = AW'(DEPTH - 1);

  logic [AW-1:0] q, nxt;

  generate
    if (DEPTH == (1 << AW)) begin : g_pow2
      assign nxt = q + 1'b1;
    end else begin : g_cmp
      assign nxt = (q == TOP) ? '0 : q + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= load_val;
    else if (step) q <= nxt;
  end

  assign addr = q;

  // R12: wrap at the top of the range
  p_wrap_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && q == TOP) |=> (q == '0));
  // R4 and R5: one step per granted word
  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && q != TOP) |=> (q == $past(q) + 1'b1));
  // R8: address holds without a step
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load) |=> $stable(q));
endmodule

// File: rtl/bx_word_ctr.sv
module bx_word_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         last
);
  logic [W-1:0] rem;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rem <= '0;
    else if (load) rem <= load_val;
    else if (dec)  rem <= rem - 1'b1;
  end

  assign last = (rem == W'(1));

  // R10: a word is never taken past the programmed count
  p_no_underflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load) |-> (rem != '0));
endmodule

// File: rtl/blk_xfer_eng.sv
module blk_xfer_eng
  import blk_xfer_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int LCL_DEPTH = 64,
  parameter int SHR_AW    = 16,
  parameter int CNT_W     = 8,
  localparam int LCL_AW   = $clog2(LCL_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  cfg_count,
  input  logic [LCL_AW-1:0] cfg_lcl_addr,
  input  logic [SHR_AW-1:0] cfg_shr_addr,
  input  logic              cfg_dir,
  input  logic              cfg_lcl_inc,
  input  logic              cfg_shr_inc,
  output logic              busy,
  output logic              done,
  output logic [LCL_AW-1:0] lcl_addr,
  output logic              lcl_we,
  output logic [DATA_W-1:0] lcl_wdata,
  input  logic [DATA_W-1:0] lcl_rdata,
  output logic              shr_req,
  input  logic              shr_gnt,
  output logic              shr_we,
  output logic [SHR_AW-1:0] shr_addr,
  output logic [DATA_W-1:0] shr_wdata,
  input  logic [DATA_W-1:0] shr_rdata
);
  localparam int SHR_DEPTH = 1 << SHR_AW;

  bx_state_e state_q;
  bx_mode_t  mode_q;
  logic      done_q;
  logic      accept, launch, beat, last_beat;

  assign accept = start && (state_q == ST_IDLE);
  assign launch = accept && (cfg_count != '0);
  assign beat   = (state_q == ST_RUN) && shr_gnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mode_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        if (cfg_count == '0) begin
          done_q <= 1'b1;
        end else begin
          state_q <= ST_RUN;
          mode_q  <= '{to_shared: cfg_dir, lcl_step: cfg_lcl_inc, shr_step: cfg_shr_inc};
        end
      end else if (beat && last_beat) begin
        state_q <= ST_IDLE;
        done_q  <= 1'b1;
      end
    end
  end

  bx_addr_gen #(.AW(LCL_AW), .DEPTH(LCL_DEPTH)) u_lcl_addr (
    .clk(clk), .rst_n(rst_n), .load(launch), .load_val(cfg_lcl_addr),
    .step(beat && mode_q.lcl_step), .addr(lcl_addr)
  );

  bx_addr_gen #(.AW(SHR_AW), .DEPTH(SHR_DEPTH)) u_shr_addr (
    .clk(clk), .rst_n(rst_n), .load(launch), .load_val(cfg_shr_addr),
    .step(beat && mode_q.shr_step), .addr(shr_addr)
  );

  bx_word_ctr #(.W(CNT_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .load(launch), .load_val(cfg_count),
    .dec(beat), .last(last_beat)
  );

  assign busy      = (state_q == ST_RUN);
  assign done      = done_q;
  assign shr_req   = busy;
  assign shr_we    = busy && (mode_q.to_shared == DIR_LCL_TO_SHR);
  assign shr_wdata = lcl_rdata;
  assign lcl_we    = beat && (mode_q.to_shared == DIR_SHR_TO_LCL);
  assign lcl_wdata = shr_rdata;

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_zero_cnt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && cfg_count == '0) |=> (done && !shr_req));
  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (shr_req && !shr_gnt) |=> (shr_req && $stable(shr_addr) && $stable(lcl_addr)));
  p_lcl_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lcl_we |-> (shr_req && shr_gnt && !shr_we));
  p_shr_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    shr_we |-> (shr_req && !lcl_we));
  p_start_ign_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !shr_gnt) |=> (busy && $stable(shr_addr) && $stable(lcl_addr)));
endmodule

// File: tb/blk_xfer_eng_tb_top.sv
`timescale 1ns/1ps
module blk_xfer_eng_tb_top;
  localparam int DW  = 32;
  localparam int LD  = 64;
  localparam int SAW = 8;
  localparam int SD  = 256;
  localparam int CW  = 8;
  localparam int LAW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [CW-1:0]  cfg_count = '0;
  logic [LAW-1:0] cfg_lcl_addr = '0;
  logic [SAW-1:0] cfg_shr_addr = '0;
  logic cfg_dir = 1'b0, cfg_lcl_inc = 1'b0, cfg_shr_inc = 1'b0;
  logic busy, done, lcl_we, shr_req, shr_we;
  logic shr_gnt = 1'b0;
  logic [LAW-1:0] lcl_addr;
  logic [SAW-1:0] shr_addr;
  logic [DW-1:0]  lcl_wdata, lcl_rdata, shr_wdata, shr_rdata;

  logic [DW-1:0] lmem [LD];
  logic [DW-1:0] smem [SD];

  int checks = 0;
  int fails  = 0;
  int beats  = 0;
  int gmode  = 0;
  logic [7:0] lfsr = 8'hA5;

  always #4 clk = ~clk;

  blk_xfer_eng #(.DATA_W(DW), .LCL_DEPTH(LD), .SHR_AW(SAW), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_count(cfg_count),
    .cfg_lcl_addr(cfg_lcl_addr), .cfg_shr_addr(cfg_shr_addr), .cfg_dir(cfg_dir),
    .cfg_lcl_inc(cfg_lcl_inc), .cfg_shr_inc(cfg_shr_inc), .busy(busy), .done(done),
    .lcl_addr(lcl_addr), .lcl_we(lcl_we), .lcl_wdata(lcl_wdata), .lcl_rdata(lcl_rdata),
    .shr_req(shr_req), .shr_gnt(shr_gnt), .shr_we(shr_we), .shr_addr(shr_addr),
    .shr_wdata(shr_wdata), .shr_rdata(shr_rdata)
  );

  assign lcl_rdata = lmem[lcl_addr];
  assign shr_rdata = smem[shr_addr];

  always @(posedge clk) begin
    if (lcl_we) lmem[lcl_addr] <= lcl_wdata;
    if (shr_req && shr_gnt && shr_we) smem[shr_addr] <= shr_wdata;
    if (shr_req && shr_gnt) beats <= beats + 1;
  end

  function automatic logic [DW-1:0] lval(int i); return 32'h5000_0000 + i; endfunction
  function automatic logic [DW-1:0] sval(int i); return 32'hA000_0000 + i; endfunction

  task automatic preload();
    for (int i = 0; i < LD; i++) lmem[i] = lval(i);
    for (int i = 0; i < SD; i++) smem[i] = sval(i);
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    case (gmode)
      0: shr_gnt = 1'b1;
      1: begin lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]}; shr_gnt = lfsr[0]; end
      default: shr_gnt = 1'b0;
    endcase
  endtask

  task automatic launch(input int cnt, input int la, input int sa,
                        input bit dir, input bit li, input bit si);
    tick();
    start = 1'b1; cfg_count = CW'(cnt); cfg_lcl_addr = LAW'(la);
    cfg_shr_addr = SAW'(sa); cfg_dir = dir; cfg_lcl_inc = li; cfg_shr_inc = si;
    tick();
    start = 1'b0;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    while (!done && cyc < 2000) begin tick(); cyc++; end
    if (cyc >= 2000) check(1'b0, "R10", "done timeout", 32'(cyc), 32'd0);
  endtask

  task automatic t_reset();
    check(!busy && !done, "R1", "busy/done after reset", {busy, done}, 0);
    check(!shr_req && !shr_we && !lcl_we, "R1", "req/we after reset",
          {shr_req, shr_we, lcl_we}, 0);
  endtask

  task automatic t_copy_read();
    int cyc, b0;
    preload(); gmode = 0; b0 = beats;
    launch(8, 4, 10, 1'b0, 1'b1, 1'b1);
    wait_done(cyc);
    check(cyc == 8, "R10", "latency for 8 words", cyc, 8);
    check(!busy, "R10", "busy with done", busy, 0);
    for (int k = 0; k < 8; k++)
      check(lmem[4+k] == sval(10+k), "R2", "copied word", lmem[4+k], sval(10+k));
    check(lmem[12] == lval(12), "R4", "word past block", lmem[12], lval(12));
    check(beats - b0 == 8, "R2", "access count", beats - b0, 8);
    tick();
    check(!done, "R10", "done one cycle", done, 0);
  endtask

  task automatic t_copy_write();
    int cyc, b0;
    preload(); gmode = 1; b0 = beats;
    launch(6, 20, 40, 1'b1, 1'b1, 1'b1);
    wait_done(cyc);
    for (int k = 0; k < 6; k++)
      check(smem[40+k] == lval(20+k), "R3", "written word", smem[40+k], lval(20+k));
    check(smem[46] == sval(46), "R3", "word past block", smem[46], sval(46));
    check(lmem[20] == lval(20), "R3", "local untouched", lmem[20], lval(20));
    check(beats - b0 == 6, "R8", "no lost or extra word", beats - b0, 6);
  endtask

  task automatic t_stall();
    int cyc;
    preload(); gmode = 2;
    launch(3, 0, 128, 1'b0, 1'b1, 1'b1);
    for (int k = 0; k < 5; k++) begin
      tick();
      check(busy && shr_req && !lcl_we, "R8", "stalled req", {busy, shr_req, lcl_we}, 3'b110);
      check(shr_addr == 8'd128 && lcl_addr == 6'd0, "R8", "stalled addr",
            {lcl_addr, shr_addr}, {6'd0, 8'd128});
    end
    check(lmem[0] == lval(0), "R8", "no write in stall", lmem[0], lval(0));
    gmode = 0;
    wait_done(cyc);
    for (int k = 0; k < 3; k++)
      check(lmem[k] == sval(128+k), "R8", "word after stall", lmem[k], sval(128+k));
  endtask

  task automatic t_start_busy();
    int cyc, b0;
    preload(); gmode = 2; b0 = beats;
    launch(2, 50, 144, 1'b0, 1'b1, 1'b1);
    start = 1'b1; cfg_count = 8'd5; cfg_lcl_addr = 6'd55; cfg_shr_addr = 8'd200;
    tick();
    start = 1'b0;
    check(shr_addr == 8'd144, "R11", "addr kept", shr_addr, 144);
    gmode = 0;
    wait_done(cyc);
    check(beats - b0 == 2, "R11", "count kept", beats - b0, 2);
    check(lmem[55] == lval(55), "R11", "second target untouched", lmem[55], lval(55));
    check(lmem[51] == sval(145), "R11", "first transfer done", lmem[51], sval(145));
  endtask

  task automatic t_zero();
    int cyc, b0;
    gmode = 0; b0 = beats;
    launch(0, 3, 3, 1'b0, 1'b1, 1'b1);
    wait_done(cyc);
    check(cyc == 0 && done, "R9", "done next cycle", cyc, 0);
    tick();
    check(!done && !busy, "R9", "idle after zero", {done, busy}, 0);
    check(beats == b0, "R9", "no access", beats - b0, 0);
  endtask

  task automatic t_fill();
    int cyc;
    preload(); gmode = 1;
    lmem[7] = 32'hDEAD_BEEF;
    launch(10, 7, 100, 1'b1, 1'b0, 1'b1);
    wait_done(cyc);
    for (int k = 0; k < 10; k++)
      check(smem[100+k] == 32'hDEAD_BEEF, "R6", "fill word", smem[100+k], 32'hDEAD_BEEF);
    check(smem[99] == sval(99), "R6", "below region", smem[99], sval(99));
    check(smem[110] == sval(110), "R6", "above region", smem[110], sval(110));
  endtask

  task automatic t_single();
    int cyc, b0;
    preload(); gmode = 0; b0 = beats;
    launch(1, 30, 50, 1'b0, 1'b0, 1'b1);
    wait_done(cyc);
    check(lmem[30] == sval(50), "R7", "first fetch", lmem[30], sval(50));
    check(beats - b0 == 1, "R7", "one access", beats - b0, 1);
    launch(1, 30, 51, 1'b0, 1'b0, 1'b1);
    wait_done(cyc);
    check(lmem[30] == sval(51), "R7", "second fetch", lmem[30], sval(51));
    check(lmem[31] == lval(31), "R7", "next slot untouched", lmem[31], lval(31));
  endtask

  task automatic t_fixed_side();
    int cyc;
    preload(); gmode = 1;
    launch(4, 40, 60, 1'b0, 1'b1, 1'b0);
    wait_done(cyc);
    for (int k = 0; k < 4; k++)
      check(lmem[40+k] == sval(60), "R5", "fixed shared source", lmem[40+k], sval(60));
    launch(3, 44, 70, 1'b1, 1'b1, 1'b0);
    wait_done(cyc);
    check(smem[70] == lval(46), "R5", "fixed shared sink", smem[70], lval(46));
    check(smem[71] == sval(71), "R5", "sink neighbour", smem[71], sval(71));
    launch(3, 9, 80, 1'b0, 1'b0, 1'b1);
    wait_done(cyc);
    check(lmem[9] == sval(82), "R4", "fixed local slot", lmem[9], sval(82));
    check(lmem[10] == lval(10), "R4", "local neighbour", lmem[10], lval(10));
  endtask

  task automatic t_wrap();
    int cyc;
    preload(); gmode = 0;
    launch(4, 62, 254, 1'b0, 1'b1, 1'b1);
    wait_done(cyc);
    check(lmem[62] == sval(254), "R12", "pre-wrap 0", lmem[62], sval(254));
    check(lmem[63] == sval(255), "R12", "pre-wrap 1", lmem[63], sval(255));
    check(lmem[0] == sval(0), "R12", "post-wrap 0", lmem[0], sval(0));
    check(lmem[1] == sval(1), "R12", "post-wrap 1", lmem[1], sval(1));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    preload();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_copy_read();
    t_copy_write();
    t_stall();
    t_start_busy();
    t_zero();
    t_fill();
    t_single();
    t_fixed_side();
    t_wrap();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule